// File: doc/BRIEF.md
# Microcoded Sequential FIR Filter

A four-tap, third-order FIR filter built around one time-shared multiply-accumulate datapath. A small stored microprogram drives it, so the block has no hard-wired state machine. A microprogram counter addresses a constant control ROM. The ROM word is registered, and that registered word drives the datapath. Each word carries a branch-select bit and a 4-bit branch target, followed by seven control bits: a tap load enable with its 2-bit register select, a delay-line clear, a sample shift, a multiply-accumulate sweep and an output latch.

After reset the microprogram runs the coefficient-load words once, reading the coefficient bus one tap per cycle. It then falls into a loop that never returns to the load words. Each pass of the loop does four things:

- It shifts one sample into the delay line and clears the accumulator.
- It sweeps the taps through the shared multiplier while the sequencer is held.
- It copies the 16-bit accumulator into the output latch.
- It branches back to the shift word.

Samples and coefficients are signed two's complement. The accumulator wraps modulo 2^16.

Top module: `fir_mpcu`

## Requirements
- R1: A synchronous active-high reset sets the microprogram counter to address 0 and sets the output latch and the accumulator to zero. The output reads 0 after reset.
- R2: The ROM words at addresses 0 to 3 load the coefficient registers in turn. The word at address k uses select value k and loads coefficient register k, which weights the sample k steps old. The word at address k takes the coefficient bus on the (k+2)-th rising edge after reset is released, counting the first edge with reset low as edge 1.
- R3: The ROM word at address 3 also clears every sample register to zero. Samples left over from before a reset therefore do not reach the first results.
- R4: The ROM word at address 4 shifts the sample bus into the newest delay-line register, moves the older samples along by one, and clears the accumulator.
- R5: The ROM word at address 5 runs one multiply-accumulate per tap, for 4 consecutive cycles, in tap order 0 to 3. The microprogram counter and the registered word hold until the last tap is done.
- R6: The output changes only when the ROM word at address 6 executes, and then takes the accumulator value. It is stable in every other cycle.
- R7: The ROM word at address 7 has branch-select 1 and target 4. With branch-select 0 the counter increments. The coefficient registers are therefore never reloaded, and the coefficient bus is ignored once loading is done.
- R8: The sum of products is kept modulo 2^16. With all samples and coefficients at -128, the outputs are 0x4000, 0x8000, 0xC000 and then 0x0000.
- R9: One sample is taken every 7 cycles. The result for a sample appears in the output latch 5 rising edges after the edge that shifted the sample in. It equals the sum over k of coefficient k times the sample k steps old, using signed arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | 8 | Signed input sample, taken when the shift word executes |
| coef_in | input | 8 | Signed coefficient, taken while a load word executes |
| y_out | output | 16 | Latched filter result, signed, modulo 2^16 |

## Verification
An impulse followed by zeros returns the loaded coefficients one per frame. This separates a wrong tap order or register select from an arithmetic fault. A run with every operand at -128 exercises the sign handling and the 16-bit wrap, and because it follows a run with random data it also shows whether the delay-line clear works. Random signed samples are mixed with a random coefficient bus after loading. These frames distinguish a correct branch that skips the load words from one that reloads the taps. The output is sampled one cycle before and one cycle after each expected update, which catches a latch that fires early or late.

// File: rtl/fir_mpcu_pkg.sv
package fir_mpcu_pkg;

  localparam int BR_W  = 4;
  localparam int SEL_W = 2;

  // 12-bit control word: branch select, branch target, then control bits
  typedef struct packed {
    logic             cond;
    logic [BR_W-1:0]  br;
    logic             load;
    logic [SEL_W-1:0] sel;
    logic             clr;
    logic             shift;
    logic             mac;
    logic             latch;
  } uword_t;

  // Computed control ROM contents for a filter of ntaps taps
  function automatic uword_t rom_word(input logic [BR_W-1:0] a, input int ntaps);
    uword_t w;
    int     ai;
    w  = '0;
    ai = int'(a);
    if (ai < ntaps) begin
      w.load = 1'b1;
      w.sel  = SEL_W'(ai);
      w.clr  = (ai == ntaps - 1);
    end else if (ai == ntaps) begin
      w.shift = 1'b1;
    end else if (ai == ntaps + 1) begin
      w.mac = 1'b1;
    end else if (ai == ntaps + 2) begin
      w.latch = 1'b1;
    end else begin
      w.cond = 1'b1;
      w.br   = BR_W'(ntaps);
    end
    return w;
  endfunction

endpackage

// File: rtl/fir_mpcu_seq.sv
module fir_mpcu_seq
  import fir_mpcu_pkg::*;
#(
  parameter int NTAPS = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   hold,
  output uword_t uw_q
);

  logic [BR_W-1:0] pc;
  uword_t          cur;

  always_comb cur = rom_word(pc, NTAPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      uw_q <= '0;
    end else if (!hold) begin
      uw_q <= cur;
      pc   <= cur.cond ? cur.br : pc + 1'b1;
    end
  end

  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!hold && cur.cond) |=> (pc == $past(cur.br)));                     // R7
  AST_STEP_INCR: assert property (@(posedge clk) disable iff (rst)
    (!hold && !cur.cond) |=> (pc == $past(pc) + 1'b1));                 // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(pc) && $stable(uw_q)));                           // R5

endmodule

// File: rtl/fir_mpcu_datapath.sv
module fir_mpcu_datapath
  import fir_mpcu_pkg::*;
#(
  parameter int NTAPS = 4,
  parameter int DW    = 8,
  parameter int AW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic             clr_smp,
  input  logic             shift,
  input  logic             mac,
  input  logic             latch,
  input  logic [DW-1:0]    sample_in,
  input  logic [DW-1:0]    coef_in,
  output logic             hold,
  output logic [AW-1:0]    y
);

  localparam int PW = 2 * DW;
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NTAPS - 1);

  logic signed [DW-1:0] smp  [NTAPS];
  logic signed [DW-1:0] coef [NTAPS];
  logic [NTAPS-1:0]     coef_we;
  logic [SEL_W-1:0]     tidx;
  logic signed [DW-1:0] d_sel, c_sel;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext, acc, acc_d;

  // Load-select decoder and coefficient registers
  for (genvar i = 0; i < NTAPS; i++) begin : g_coef
    assign coef_we[i] = ld_en && (ld_sel == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (coef_we[i]) coef[i] <= coef_in;
    end
  end

  // Delay line: entry 0 is the newest sample
  for (genvar i = 0; i < NTAPS; i++) begin : g_smp
    always_ff @(posedge clk) begin
      if (clr_smp)    smp[i] <= '0;
      else if (shift) smp[i] <= (i == 0) ? sample_in : smp[(i == 0) ? 0 : i - 1];
    end
  end

  // Tap index for the multiply-accumulate sweep
  always_ff @(posedge clk) begin
    if (rst)      tidx <= '0;
    else if (mac) tidx <= (tidx == LAST) ? '0 : tidx + 1'b1;
  end

  assign hold = mac && (tidx != LAST);

  // Data and tap multiplexers, multiplier, dataflow mux
  always_comb begin
    d_sel    = smp[tidx];
    c_sel    = coef[tidx];
    prod     = d_sel * c_sel;
    prod_ext = AW'(prod);
    acc_d    = shift ? '0 : acc + prod_ext;
  end

  always_ff @(posedge clk) begin
    if (rst)               acc <= '0;
    else if (shift || mac) acc <= acc_d;
  end

  always_ff @(posedge clk) begin
    if (rst)        y <= '0;
    else if (latch) y <= acc;
  end

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    shift |=> (acc == '0));                                             // R4
  AST_TAP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (mac && tidx == LAST) |=> (tidx == '0));                            // R5
  AST_Y_HELD: assert property (@(posedge clk) disable iff (rst)
    !latch |=> $stable(y));                                             // R6
  AST_Y_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    latch |=> (y == $past(acc)));                                       // R6
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_en, shift, mac, latch}));                              // R2

endmodule

// File: rtl/fir_mpcu.sv
module fir_mpcu
  import fir_mpcu_pkg::*;
#(
  parameter int NTAPS = 4,
  parameter int DW    = 8,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sample_in,
  input  logic [DW-1:0] coef_in,
  output logic [AW-1:0] y_out
);

  uword_t uw_q;
  logic   hold;

  fir_mpcu_seq #(.NTAPS(NTAPS)) i_seq (
    .clk  (clk),
    .rst  (rst),
    .hold (hold),
    .uw_q (uw_q)
  );

  fir_mpcu_datapath #(.NTAPS(NTAPS), .DW(DW), .AW(AW)) i_dp (
    .clk       (clk),
    .rst       (rst),
    .ld_en     (uw_q.load),
    .ld_sel    (uw_q.sel),
    .clr_smp   (uw_q.clr),
    .shift     (uw_q.shift),
    .mac       (uw_q.mac),
    .latch     (uw_q.latch),
    .sample_in (sample_in),
    .coef_in   (coef_in),
    .hold      (hold),
    .y         (y_out)
  );

endmodule

// File: tb/test_fir_mpcu.sv
module test_fir_mpcu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  sample_in = '0;
  logic [7:0]  coef_in = '0;
  logic [15:0] y_out;

  int checks = 0;
  int errors = 0;

  logic signed [7:0] cf   [4];
  logic signed [7:0] hist [4];

  always #5 clk = ~clk;

  fir_mpcu i_fir_mpcu (
    .clk(clk), .rst(rst), .sample_in(sample_in), .coef_in(coef_in), .y_out(y_out)
  );

  function automatic logic [15:0] model();
    int s = 0;
    for (int k = 0; k < 4; k++) s += int'(cf[k]) * int'(hist[k]);
    return s[15:0];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset output", y_out, 16'h0000);
    rst = 1'b0;
  endtask

  // mode 0: impulse then random; mode 1: all -128
  task automatic run_pass(input int nsamp, input int mode);
    logic [15:0] prev;
    logic signed [7:0] x;
    @(posedge clk);                       // edge 1 after release
    for (int k = 0; k < 4; k++) begin     // R2 load schedule
      @(negedge clk) coef_in = cf[k];
      @(posedge clk);
    end
    for (int k = 0; k < 4; k++) hist[k] = '0;   // R3 delay line cleared
    prev = 16'h0000;
    for (int n = 0; n < nsamp; n++) begin
      if (mode == 1)      x = -8'sd128;
      else if (n == 0)    x = 8'sd1;
      else if (n < 4)     x = 8'sd0;
      else if (n == 4)    x = 8'sd127;
      else                x = 8'($urandom);
      @(negedge clk);
      sample_in = x;
      coef_in   = 8'($urandom);           // R7 ignored after loading
      for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      @(posedge clk);                     // shift edge
      repeat (4) @(posedge clk);          // sweep, R5
      @(negedge clk);
      chk("R6 output held before latch", y_out, prev);
      @(posedge clk);                     // latch edge, R9 timing
      @(negedge clk);
      prev = model();
      chk(mode == 1 ? "R8 wrap" : "R9 convolution", y_out, prev);
      @(posedge clk);                     // branch word
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    cf[0] = 8'sd3; cf[1] = -8'sd5; cf[2] = 8'sd7; cf[3] = -8'sd128;
    run_pass(24, 0);                      // R2, R4, R7, R9
    do_reset();                           // R1 after nonzero output
    for (int k = 0; k < 4; k++) cf[k] = -8'sd128;
    run_pass(6, 1);                       // R3, R8
    do_reset();
    for (int k = 0; k < 4; k++) cf[k] = 8'($urandom);
    run_pass(20, 0);                      // R9 random taps
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule